// File: doc/BRIEF.md
# Warp-Level Tiled Matrix Multiply-Accumulate Sequencer

This block computes D = A x B + C for a 32-lane group in one operation. A is M x 16, B is 16 x N and C and D are M x N, where the shape is 16x16, 32x8 or 8x32. Each lane supplies its share of the operands as packed fragments. The block splits the work among eight groups of four neighbouring lanes. Each group owns an 8-row by 4-column chunk of the result. The inner dimension is covered in four sets of four k values, and each set is added into the running accumulator before the next set starts. A set is made of steps, and each step updates one sub-tile of every group's chunk at the same time.

The sequencer is started with a one-cycle pulse that carries the shape code and the precision mode. In full-precision mode the accumulator is 32 bits wide and each set has four steps, each updating a 4x2 sub-tile. In half-precision mode the accumulator is 16 bits wide and each set has two steps, each updating a 4x4 sub-tile. Element arithmetic is unsigned integer: 8-bit operands and a wrapping accumulator. This keeps the tiling order and the fragment placement exactly checkable. The operation only runs when every lane is active. Otherwise it is refused and the destination is left as it was.

Top module: `mma_seq_top`

## Requirements
- R1: With shape code 0 (16x16x16) and full precision, after completion each D element equals (C + sum over k of A(r,k)*B(k,c)) modulo 2^32, with unsigned 8-bit operands.
- R2: Shape code 1 selects M=32, N=8, and shape code 2 selects M=8, N=32, both with inner dimension 16. Shape code 3 is not an operation.
- R3: Operand fragments: lane L, value j (bits [(L*16+j)*8 +: 8] of the A and B inputs) holds A(L,j) for L < M and B(j,L) for L < N. Lanes at or above M (for A) or N (for B) are never read.
- R4: Accumulator and result fragments: lane L, value v (bits [(L*8+v)*32 +: 32]) holds the element with row rb*8 + 2*(L%4) + v/4 and column cb*4 + v%4. Here g = L/4, nb = N/4, rb = g/nb and cb = g%nb.
- R5: The result port shows the accumulator at every cycle. After step t, with s = t/S the set and p = t%S the step within the set, a chunk element (chunk row cr, chunk column cc) holds C plus the products of k sets 0..s if its step index is at most p, and of sets 0..s-1 otherwise. The step index is (cr/4)*2 + cc/2 in full mode and cr/4 in half mode.
- R6: An accepted start raises busy in the next cycle. Busy stays high for exactly 4*S cycles (S = 4 in full mode, 2 in half mode). The cycle after the last step shows done high and busy low, and done lasts one cycle.
- R7: In half-precision mode only the low 16 bits of each C value are loaded, the accumulator wraps modulo 2^16, and the upper 16 bits of every result value are zero.
- R8: A start while any lane_active bit is 0, or with shape code 3, gives a one-cycle err pulse in the next cycle. No busy follows, and the result port is unchanged.
- R9: A start, shape or mode change while busy is ignored. The running operation continues unchanged.
- R10: After reset, busy, done and err are low and every result value is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle launch request |
| shape | input | 2 | 0: 16x16x16, 1: 32x8x16, 2: 8x32x16 |
| half_acc | input | 1 | 1 selects half-precision (16-bit) accumulation |
| lane_active | input | 32 | Per-lane participation mask |
| a_frag | input | 4096 | A fragments, 16 x 8-bit values per lane |
| b_frag | input | 4096 | B fragments, 16 x 8-bit values per lane |
| c_frag | input | 8192 | Accumulator fragments, 8 x 32-bit values per lane |
| d_frag | output | 8192 | Result fragments, 8 x 32-bit values per lane |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle refusal pulse |

## Verification
The hardest property to observe is the set ordering. Integer sums commute, so the final result alone cannot show whether the sets and steps ran in the required order. The bench therefore samples the result port after every single step and compares each of the 256 values against the partial sum predicted for that step, in both precision modes and all three shapes. Lanes that must not be read are filled with unrelated data, so any wrong lane selection shows up in these comparisons. Control inputs are also changed mid-run to show that the running operation does not react.

// File: rtl/mma_seq_pkg.sv
package mma_seq_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int NLANE  = 32;  // lanes in the cooperating group
   localparam int GLANES = 4;   // lanes per tile group
   localparam int NGRP   = NLANE / GLANES;
   localparam int KDIM   = 16;  // inner dimension
   localparam int KSET   = 4;   // k values handled per set
   localparam int NSET   = KDIM / KSET;
   localparam int NVAL   = 8;   // accumulator values per lane
   localparam int CROWS  = 8;   // chunk rows per group
   localparam int CCOLS  = 4;   // chunk columns per group
   localparam int SLOTS  = 16;  // widest step: 4x4 sub-tile

   typedef enum logic [1:0] {
      SHP_SQ   = 2'd0,
      SHP_TALL = 2'd1,
      SHP_WIDE = 2'd2,
      SHP_BAD  = 2'd3
   } shape_e;

   // number of 4-column blocks across N
   function automatic int col_blocks(input shape_e s);
      case (s)
         SHP_TALL: col_blocks = 2;
         SHP_WIDE: col_blocks = 8;
         default:  col_blocks = 4;
      endcase
   endfunction
endpackage

// File: rtl/mma_seq_dot4.sv
module mma_seq_dot4 #(
   parameter int DW = 8,
   parameter int N  = 4,
   parameter int PW = 18
) (
   input  logic [N-1:0][DW-1:0] a,
   input  logic [N-1:0][DW-1:0] b,
   output logic [PW-1:0]        sum
);
   timeunit 1ns;
   timeprecision 1ps;

   logic [N-1:0][2*DW-1:0] prod;

   for (genvar i = 0; i < N; i++) begin : g_mul
      assign prod[i] = a[i] * b[i];
   end

   always_comb begin
      sum = '0;
      for (int i = 0; i < N; i++) sum = sum + PW'(prod[i]);
   end
endmodule

// File: rtl/mma_seq_ctrl.sv
module mma_seq_ctrl
   import mma_seq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  shape_e           shape,
   input  logic             half_acc,
   input  logic [NLANE-1:0] lane_active,
   output logic             accept,
   output logic             busy,
   output logic             done,
   output logic             err,
   output logic             half_q,
   output shape_e           shape_q,
   output logic [1:0]       set_idx,
   output logic [1:0]       step_idx
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int CW = $clog2(NSET * 4);

   logic [CW-1:0] cnt;
   logic          ok, last;
   int            sps;

   assign ok     = (&lane_active) && (shape != SHP_BAD);
   assign accept = start && !busy && ok;

   always_comb begin
      sps      = half_q ? 2 : 4;
      set_idx  = 2'(int'(cnt) / sps);
      step_idx = 2'(int'(cnt) % sps);
      last     = (int'(cnt) == NSET * sps - 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         busy    <= 1'b0;
         done    <= 1'b0;
         err     <= 1'b0;
         half_q  <= 1'b0;
         shape_q <= SHP_SQ;
      end else begin
         done <= 1'b0;
         err  <= 1'b0;
         if (busy) begin
            cnt <= cnt + 1'b1;
            if (last) begin
               busy <= 1'b0;
               done <= 1'b1;
               cnt  <= '0;
            end
         end else if (start) begin
            if (ok) begin
               busy    <= 1'b1;
               cnt     <= '0;
               half_q  <= half_acc;
               shape_q <= shape;
            end else begin
               err <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/mma_seq_group.sv
module mma_seq_group
   import mma_seq_pkg::*;
#(
   parameter int G  = 0,
   parameter int DW = 8,
   parameter int PW = 18
) (
   input  logic [NLANE*KDIM*DW-1:0] a_q,
   input  logic [NLANE*KDIM*DW-1:0] b_q,
   input  shape_e                   shape,
   input  logic                     half,
   input  logic [1:0]               set_idx,
   input  logic [1:0]               step_idx,
   output logic [SLOTS-1:0]         en,
   output logic [SLOTS-1:0][4:0]    lane,
   output logic [SLOTS-1:0][2:0]    val,
   output logic [SLOTS-1:0][PW-1:0] sum
);
   timeunit 1ns;
   timeprecision 1ps;

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic                     en_s;
      logic [4:0]               lane_s;
      logic [2:0]               val_s;
      logic [KSET-1:0][DW-1:0]  av, bv;
      logic [PW-1:0]            sum_s;

      always_comb begin
         int cr, cc, nb, row, col, kb;
         if (half) begin
            // 4x4 sub-tile: rows step*4.., all four columns
            cr   = int'(step_idx) * 4 + s / 4;
            cc   = s % 4;
            en_s = 1'b1;
         end else begin
            // 4x2 sub-tile: row half from step[1], column pair from step[0]
            cr   = (int'(step_idx) / 2) * 4 + (s / 2) % 4;
            cc   = (int'(step_idx) % 2) * 2 + s % 2;
            en_s = (s < SLOTS / 2);
         end
         nb     = col_blocks(shape);
         row    = (G / nb) * CROWS + cr;
         col    = (G % nb) * CCOLS + cc;
         kb     = int'(set_idx) * KSET;
         lane_s = 5'(G * GLANES + cr / 2);
         val_s  = 3'((cr % 2) * CCOLS + cc);
         for (int i = 0; i < KSET; i++) begin
            av[i] = a_q[(row * KDIM + kb + i) * DW +: DW];
            bv[i] = b_q[(col * KDIM + kb + i) * DW +: DW];
         end
      end

      mma_seq_dot4 #(.DW(DW), .N(KSET), .PW(PW)) u_dot (
         .a  (av),
         .b  (bv),
         .sum(sum_s)
      );

      assign en[s]   = en_s;
      assign lane[s] = lane_s;
      assign val[s]  = val_s;
      assign sum[s]  = sum_s;
   end
endmodule

// File: rtl/mma_seq_top.sv
module mma_seq_top
   import mma_seq_pkg::*;
#(
   parameter int DW = 8,
   parameter int AW = 32,
   parameter int HW = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [1:0]               shape,
   input  logic                     half_acc,
   input  logic [31:0]              lane_active,
   input  logic [32*16*DW-1:0]      a_frag,
   input  logic [32*16*DW-1:0]      b_frag,
   input  logic [32*8*AW-1:0]       c_frag,
   output logic [32*8*AW-1:0]       d_frag,
   output logic                     busy,
   output logic                     done,
   output logic                     err
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int PW = 2 * DW + $clog2(KSET);
   localparam logic [AW-1:0] HMASK = AW'((64'd1 << HW) - 1);

   if (HW < 1 || HW > AW) begin : g_bad_hw
      $error("half accumulator width must lie within the slot width");
   end
   if (PW > AW) begin : g_bad_pw
      $error("slot width too small for one set of products");
   end
   if (NGRP * GLANES != NLANE || NSET * KSET != KDIM) begin : g_bad_geo
      $error("lane grouping or k split inconsistent");
   end

   logic       accept, half_q;
   shape_e     shape_q;
   logic [1:0] set_idx, step_idx;

   logic [NLANE*KDIM*DW-1:0] a_q, b_q;
   logic [AW-1:0]            acc [NLANE][NVAL];

   logic [NGRP-1:0][SLOTS-1:0]         g_en;
   logic [NGRP-1:0][SLOTS-1:0][4:0]    g_lane;
   logic [NGRP-1:0][SLOTS-1:0][2:0]    g_val;
   logic [NGRP-1:0][SLOTS-1:0][PW-1:0] g_sum;

   mma_seq_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .shape      (shape_e'(shape)),
      .half_acc   (half_acc),
      .lane_active(lane_active),
      .accept     (accept),
      .busy       (busy),
      .done       (done),
      .err        (err),
      .half_q     (half_q),
      .shape_q    (shape_q),
      .set_idx    (set_idx),
      .step_idx   (step_idx)
   );

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      mma_seq_group #(.G(g), .DW(DW), .PW(PW)) u_grp (
         .a_q     (a_q),
         .b_q     (b_q),
         .shape   (shape_q),
         .half    (half_q),
         .set_idx (set_idx),
         .step_idx(step_idx),
         .en      (g_en[g]),
         .lane    (g_lane[g]),
         .val     (g_val[g]),
         .sum     (g_sum[g])
      );
   end

   function automatic logic [AW-1:0] fold(input logic [AW-1:0] x, input logic h);
      fold = h ? (x & HMASK) : x;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= '0;
         b_q <= '0;
         for (int l = 0; l < NLANE; l++)
            for (int v = 0; v < NVAL; v++) acc[l][v] <= '0;
      end else if (accept) begin
         a_q <= a_frag;
         b_q <= b_frag;
         for (int l = 0; l < NLANE; l++)
            for (int v = 0; v < NVAL; v++)
               acc[l][v] <= fold(c_frag[(l*NVAL+v)*AW +: AW], half_acc);
      end else if (busy) begin
         for (int g = 0; g < NGRP; g++)
            for (int s = 0; s < SLOTS; s++)
               if (g_en[g][s])
                  acc[g_lane[g][s]][g_val[g][s]] <=
                     fold(acc[g_lane[g][s]][g_val[g][s]] + AW'(g_sum[g][s]), half_q);
      end
   end

   for (genvar l = 0; l < NLANE; l++) begin : g_dl
      for (genvar v = 0; v < NVAL; v++) begin : g_dv
         assign d_frag[(l*NVAL+v)*AW +: AW] = acc[l][v];
      end
   end
endmodule

// File: rtl/mma_seq_chk.sv
module mma_seq_chk
   import mma_seq_pkg::*;
#(
   parameter int AW = 32,
   parameter int HW = 16
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      start,
   input logic [1:0]                shape,
   input logic                      half_acc,
   input logic [31:0]               lane_active,
   input logic [NLANE*NVAL*AW-1:0]  d_frag,
   input logic                      busy,
   input logic                      done,
   input logic                      err
);
   timeunit 1ns;
   timeprecision 1ps;

   logic       past_ok, half_l, hi_zero;
   logic [5:0] run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         past_ok <= 1'b0;
         half_l  <= 1'b0;
         run_len <= '0;
      end else begin
         past_ok <= 1'b1;
         if (start && !busy) begin
            half_l  <= half_acc;
            run_len <= '0;
         end else if (busy) begin
            run_len <= run_len + 1'b1;
         end
      end
   end

   always_comb begin
      hi_zero = 1'b1;
      for (int i = 0; i < NLANE * NVAL; i++)
         if ((d_frag[i*AW +: AW] >> HW) != '0) hi_zero = 1'b0;
   end

   // R6: busy window length matches the precision mode
   p_run_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (run_len == (half_l ? 6'd8 : 6'd16)));

   // R6: done follows the last busy cycle and is a single pulse
   p_done_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && past_ok && $past(busy)));
   p_done_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8: refusal leaves the result untouched and never starts a run
   p_err_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!busy && $stable(d_frag)));
   p_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (past_ok && $past(start) && !$past(busy) &&
               ($past(lane_active) != '1 || $past(shape) == 2'd3)));

   // R8: idle result holds unless a start was just taken
   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(busy) && !$past(start)) |-> $stable(d_frag));

   // R9: a start during a run neither stops nor restarts it
   p_busy_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (busy || done));

   // R7: half-precision results carry no upper bits
   p_half_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && half_l) |-> hi_zero);
endmodule

bind mma_seq_top mma_seq_chk #(.AW(AW), .HW(HW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .shape      (shape),
   .half_acc   (half_acc),
   .lane_active(lane_active),
   .d_frag     (d_frag),
   .busy       (busy),
   .done       (done),
   .err        (err)
);

// File: tb/tb_mma_seq_top.sv
module tb_mma_seq_top;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int DW = 8;
   localparam int AW = 32;
   localparam int HW = 16;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, half_acc = 1'b0;
   logic [1:0]           shape = 2'd0;
   logic [31:0]          lane_active = '1;
   logic [32*16*DW-1:0]  a_frag = '0, b_frag = '0;
   logic [32*8*AW-1:0]   c_frag = '0;
   logic [32*8*AW-1:0]   d_frag;
   logic                 busy, done, err;

   mma_seq_top #(.DW(DW), .AW(AW), .HW(HW)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .shape(shape),
      .half_acc(half_acc), .lane_active(lane_active),
      .a_frag(a_frag), .b_frag(b_frag), .c_frag(c_frag),
      .d_frag(d_frag), .busy(busy), .done(done), .err(err)
   );

   always #2.5 clk = ~clk;

   int errors = 0, checks = 0;
   int am [32][16];
   int bm [16][32];
   logic [31:0] cm [32][32];
   int cur_m = 16, cur_n = 16;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // R4: lane L value v -> result row and column
   function automatic void map_rc(input int l, input int v, output int row, output int col);
      int g, q, nb;
      g = l / 4; q = l % 4; nb = cur_n / 4;
      row = (g / nb) * 8 + 2 * q + v / 4;
      col = (g % nb) * 4 + v % 4;
   endfunction

   // R5: expected accumulator after step t (t < 0: freshly loaded)
   function automatic logic [31:0] exp_d(input int l, input int v, input int t, input bit half);
      int row, col, cr, cc, sps, est, ns;
      longint acc;
      map_rc(l, v, row, col);
      cr  = row % 8; cc = col % 4;
      sps = half ? 2 : 4;
      est = half ? cr / 4 : (cr / 4) * 2 + cc / 2;
      if (t < 0) ns = 0;
      else ns = (est <= t % sps) ? t / sps + 1 : t / sps;
      acc = half ? longint'(cm[row][col] & 32'hFFFF) : longint'(cm[row][col]);
      for (int k = 0; k < ns * 4; k++) acc += longint'(am[row][k] * bm[k][col]);
      return half ? 32'(acc & 64'hFFFF) : 32'(acc);
   endfunction

   task automatic chk_frags(input int t, input bit half, input string req);
      int bad = 0;
      logic [31:0] a1 = '0, e1 = '0;
      for (int l = 0; l < 32; l++)
         for (int v = 0; v < 8; v++) begin
            logic [31:0] e, a;
            e = exp_d(l, v, t, half);
            a = d_frag[(l*8+v)*32 +: 32];
            if (a !== e && bad == 0) begin a1 = a; e1 = e; end
            if (a !== e) bad++;
         end
      check(bad == 0, req, $sformatf("result fragments R4 after step %0d", t), a1, e1);
   endtask

   // R3: only lanes below M (A) or N (B) carry operand data; others poisoned
   task automatic load(input int shp, input int seed);
      cur_m = (shp == 1) ? 32 : (shp == 2) ? 8 : 16;
      cur_n = (shp == 1) ? 8 : (shp == 2) ? 32 : 16;
      for (int r = 0; r < 32; r++)
         for (int k = 0; k < 16; k++) begin
            am[r][k] = (r * 29 + k * 13 + seed * 7 + 3) % 256;
            bm[k][r] = (k * 17 + r * 31 + seed * 3 + 5) % 256;
         end
      for (int r = 0; r < 32; r++)
         for (int c = 0; c < 32; c++)
            cm[r][c] = 32'hFFFF_8000 + 32'(r * 977 + c * 131 + seed * 4099);
      for (int l = 0; l < 32; l++)
         for (int j = 0; j < 16; j++) begin
            a_frag[(l*16+j)*8 +: 8] = (l < cur_m) ? 8'(am[l][j]) : 8'((l * 7 + j * 3 + 91) % 256);
            b_frag[(l*16+j)*8 +: 8] = (l < cur_n) ? 8'(bm[j][l]) : 8'((l * 5 + j * 11 + 47) % 256);
         end
      for (int l = 0; l < 32; l++)
         for (int v = 0; v < 8; v++) begin
            int row, col;
            map_rc(l, v, row, col);
            c_frag[(l*8+v)*32 +: 32] = cm[row][col];
         end
   endtask

   task automatic run_op(input int shp, input bit half, input int seed,
                         input bit poke, input string tag);
      int n_steps;
      n_steps = half ? 8 : 16;
      @(negedge clk);
      load(shp, seed);
      shape = 2'(shp); half_acc = half; start = 1'b1;
      @(posedge clk); @(negedge clk);
      start = 1'b0;
      check(busy === 1'b1 && done === 1'b0, "R6", {tag, " busy after start"}, busy, 1);
      chk_frags(-1, half, half ? "R7" : tag);
      for (int t = 0; t < n_steps; t++) begin
         if (poke && t == 3) begin
            // R9: new request and different controls while running
            start = 1'b1; shape = 2'((shp + 1) % 3); half_acc = !half;
         end
         @(posedge clk); @(negedge clk);
         start = 1'b0; shape = 2'(shp); half_acc = half;
         chk_frags(t, half, poke ? "R9" : (t == n_steps - 1 ? tag : "R5"));
         if (t < n_steps - 1)
            check(busy === 1'b1 && done === 1'b0, "R6", {tag, " mid-run flags"}, {busy, done}, 2'b10);
         else
            check(busy === 1'b0 && done === 1'b1, "R6", {tag, " completion flags"}, {busy, done}, 2'b01);
      end
      @(posedge clk); @(negedge clk);
      check(done === 1'b0 && busy === 1'b0, "R6", {tag, " done is one cycle"}, {busy, done}, 2'b00);
      if (half) begin
         int hi = 0;
         for (int i = 0; i < 256; i++) if (d_frag[i*32+16 +: 16] != 0) hi++;
         check(hi == 0, "R7", "upper half of results", hi, 0);
      end
   endtask

   task automatic err_case(input logic [31:0] mask, input int shp, input string what);
      logic [32*8*AW-1:0] snap;
      @(negedge clk);
      snap = d_frag;
      lane_active = mask; shape = 2'(shp); start = 1'b1;
      @(posedge clk); @(negedge clk);
      start = 1'b0;
      check(err === 1'b1 && busy === 1'b0, "R8", {what, " err pulse"}, {err, busy}, 2'b10);
      check(d_frag === snap, "R8", {what, " result unchanged"}, d_frag[31:0], snap[31:0]);
      @(posedge clk); @(negedge clk);
      check(err === 1'b0 && busy === 1'b0 && done === 1'b0, "R8", {what, " no run follows"},
            {err, busy, done}, 3'b000);
      check(d_frag === snap, "R8", {what, " result still unchanged"}, d_frag[31:0], snap[31:0]);
      lane_active = '1; shape = 2'd0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      check(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R10", "flags after reset",
            {busy, done, err}, 3'b000);
      check(d_frag === '0, "R10", "result after reset", d_frag[31:0], 0);

      run_op(0, 1'b0, 1, 1'b0, "R1");
      run_op(0, 1'b1, 2, 1'b0, "R7");
      run_op(1, 1'b0, 3, 1'b0, "R2");
      run_op(2, 1'b0, 4, 1'b0, "R3");
      run_op(1, 1'b1, 5, 1'b0, "R2");
      run_op(2, 1'b1, 6, 1'b1, "R9");
      err_case(32'hFFFF_DFFF, 0, "inactive lane 13");
      err_case(32'h7FFF_FFFF, 1, "inactive lane 31");
      err_case(32'hFFFF_FFFF, 3, "reserved shape R2");
      run_op(0, 1'b0, 7, 1'b1, "R9");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #900_000;
      errors++; checks++;
      $display("FAIL R6 watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule